// File: doc/BRIEF.md
# Radix-8 Iterative Integer Divider

This block divides one integer by another, either on 64-bit operands or on the low 32 bits of its inputs. Operands can be treated as two's complement or as unsigned. A single recurrence engine handles both modes. Each cycle of the engine resolves three quotient bits. A new operation is accepted only while the block is idle. The caller raises a start strobe for one cycle with the operands, watches the busy flag, and collects the quotient, remainder and an error flag when the done strobe pulses.

Latency depends on the data. Before the recurrence starts, the block measures how many significant bits the dividend magnitude has. It then skips every three-bit group of leading zeros, so small dividends finish sooner. Setup, magnitude conversion, sign correction and result formatting add a fixed overhead of four cycles. Two cases are treated as faults: a zero divisor, and a signed division of the most negative value by minus one. Both complete at the minimum latency.

Top module: `iter_div`

## Requirements
- R1: With signed_i low and wide_i high, the result satisfies dividend = quotient * divisor + remainder, with remainder < divisor, taken as 64-bit unsigned values.
- R2: With signed_i high, operands are two's complement, the quotient truncates toward zero, and a nonzero remainder takes the sign of the dividend.
- R3: With wide_i low, only bits [31:0] of each operand are used, bit 31 is the sign bit in signed mode, and bits [63:32] of quot_o and rem_o are zero.
- R4: A divisor whose used bits are all zero makes err_o 1, quot_o 0 and rem_o 0, with a latency of 4 cycles.
- R5: In signed mode, the most negative value of the selected width divided by all-ones gives err_o 1, quot_o 0 and rem_o 0, with a latency of 4 cycles. In unsigned mode the same bit patterns divide normally with err_o 0.
- R6: If start_i is sampled at rising edge k, done_o is high after edge k+L, where L = 4 + ceil(s/3) and s is the bit length of the dividend magnitude (0 for a zero dividend). L therefore lies in 4..15 for 32-bit operation and 4..26 for 64-bit operation.
- R7: busy_o is high from the edge that accepts start_i until the edge that raises done_o. done_o is a one-cycle pulse, and busy_o is low whenever done_o is high.
- R8: start_i while busy_o is high is ignored: the running division finishes with its own operands and latency.
- R9: After reset all outputs are zero. quot_o, rem_o and err_o change only together with a done_o pulse and hold their values in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| dividend_i | input | 64 | Dividend |
| divisor_i | input | 64 | Divisor |
| wide_i | input | 1 | 1 = 64-bit operation, 0 = 32-bit on low bits |
| signed_i | input | 1 | 1 = two's complement operands |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quot_o | output | 64 | Quotient, held until the next completion |
| rem_o | output | 64 | Remainder, held until the next completion |
| err_o | output | 1 | Fault flag for the last completed operation |

## Verification
Dividends are drawn at random and shifted right by a random amount, so their bit length sweeps every early-out group. This separates a wrong skip count from a wrong recurrence. Divisors range from one to full width, including all-ones and zero. All four sign combinations at both widths expose misplaced quotient or remainder negation. In 32-bit mode, garbage is placed in the upper operand halves to show whether they leak into the result. Directed cases sit on the group boundaries (dividends 7 and 8, zero, the full-width maximum) and on both fault patterns in each width and signedness. A second start issued mid-operation shows whether a busy divider can be disturbed.

// File: rtl/idiv_pkg.sv
`timescale 1ns/1ps
package idiv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ABS,
    ST_NORM,
    ST_ITER,
    ST_SIGN,
    ST_OUT
  } idiv_state_e;
endpackage

// File: rtl/idiv_operand.sv
`timescale 1ns/1ps
// Operand conditioning: width masking, magnitudes, sign outcome, fault detection.
module idiv_operand #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            wide_i,
  input  logic            sgn_i,
  output logic [XLEN-1:0] mag_a_o,
  output logic [XLEN-1:0] mag_b_o,
  output logic            neg_q_o,
  output logic            neg_r_o,
  output logic            err_o
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] a_w, b_w, a_neg, b_neg, min_pat, ones_pat;
  logic            sa, sb;

  always_comb begin
    a_w      = wide_i ? a_i : {{HALF{1'b0}}, a_i[HALF-1:0]};
    b_w      = wide_i ? b_i : {{HALF{1'b0}}, b_i[HALF-1:0]};
    sa       = sgn_i & (wide_i ? a_i[XLEN-1] : a_i[HALF-1]);
    sb       = sgn_i & (wide_i ? b_i[XLEN-1] : b_i[HALF-1]);
    a_neg    = -a_w;
    b_neg    = -b_w;
    if (!wide_i) begin
      a_neg = {{HALF{1'b0}}, a_neg[HALF-1:0]};
      b_neg = {{HALF{1'b0}}, b_neg[HALF-1:0]};
    end
    min_pat  = wide_i ? {1'b1, {(XLEN-1){1'b0}}}
                      : {{HALF{1'b0}}, 1'b1, {(HALF-1){1'b0}}};
    ones_pat = wide_i ? {XLEN{1'b1}} : {{HALF{1'b0}}, {HALF{1'b1}}};
    mag_a_o  = sa ? a_neg : a_w;
    mag_b_o  = sb ? b_neg : b_w;
    neg_q_o  = sa ^ sb;
    neg_r_o  = sa;
    err_o    = (b_w == '0) | (sgn_i & (a_w == min_pat) & (b_w == ones_pat));
  end
endmodule

// File: rtl/idiv_lzc.sv
`timescale 1ns/1ps
// Leading-zero counter; returns W for an all-zero input.
module idiv_lzc #(
  parameter int W  = 64,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  v_i,
  output logic [CW-1:0] lz_o
);
  always_comb begin
    lz_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (v_i[i]) lz_o = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/idiv_stage.sv
`timescale 1ns/1ps
// One iteration: DIGITS chained restoring steps, most significant bit first.
module idiv_stage #(
  parameter int W      = 64,
  parameter int DIGITS = 3
) (
  input  logic [W-1:0]      rem_i,
  input  logic [W-1:0]      den_i,
  input  logic [DIGITS-1:0] bits_i,
  output logic [W-1:0]      rem_o,
  output logic [DIGITS-1:0] q_o
);
  logic [W-1:0] part [DIGITS+1];

  assign part[0] = rem_i;

  for (genvar g = 0; g < DIGITS; g++) begin : g_step
    logic [W:0] trial;
    logic [W:0] diff;
    logic       fits;
    assign trial = {part[g], bits_i[DIGITS-1-g]};
    assign diff  = trial - {1'b0, den_i};
    assign fits  = (trial >= {1'b0, den_i});
    assign part[g+1]        = fits ? diff[W-1:0] : trial[W-1:0];
    assign q_o[DIGITS-1-g]  = fits;
  end

  assign rem_o = part[DIGITS];
endmodule

// File: rtl/iter_div.sv
`timescale 1ns/1ps
module iter_div #(
  parameter int XLEN   = 64,
  parameter int DIGITS = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [XLEN-1:0] dividend_i,
  input  logic [XLEN-1:0] divisor_i,
  input  logic            wide_i,
  input  logic            signed_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [XLEN-1:0] quot_o,
  output logic [XLEN-1:0] rem_o,
  output logic            err_o
);
  import idiv_pkg::*;

  localparam int HALF   = XLEN / 2;
  localparam int GROUPS = (XLEN + DIGITS - 1) / DIGITS;
  localparam int SHW    = GROUPS * DIGITS;
  localparam int CW     = $clog2(XLEN + 1);
  localparam int NW     = $clog2(GROUPS + 1);
  localparam int SW     = $clog2(SHW + 1);
  localparam int AW     = (CW > SW ? CW : SW) + 1;

  idiv_state_e st;

  logic [XLEN-1:0] a_raw, b_raw;
  logic            wide_r, sgn_r;
  logic [XLEN-1:0] mag_a, mag_b;
  logic            neg_q, neg_r, err_r;
  logic [SHW-1:0]  sh;
  logic [XLEN-1:0] rem_r, quo_r, q_fix, r_fix;
  logic [NW-1:0]   left;

  // operand conditioning
  logic [XLEN-1:0] pa, pb;
  logic            pnq, pnr, perr;

  idiv_operand #(.XLEN(XLEN)) u_operand (
    .a_i    (a_raw),
    .b_i    (b_raw),
    .wide_i (wide_r),
    .sgn_i  (sgn_r),
    .mag_a_o(pa),
    .mag_b_o(pb),
    .neg_q_o(pnq),
    .neg_r_o(pnr),
    .err_o  (perr)
  );

  // early-out sizing
  logic [CW-1:0] lz;
  logic [AW-1:0] sig_c, grp_c, shamt_c;
  logic [NW-1:0] n_c;

  idiv_lzc #(.W(XLEN), .CW(CW)) u_lzc (
    .v_i (mag_a),
    .lz_o(lz)
  );

  always_comb begin
    sig_c   = AW'(XLEN) - AW'(lz);
    grp_c   = (sig_c + AW'(DIGITS - 1)) / AW'(DIGITS);
    n_c     = NW'(grp_c);
    shamt_c = AW'(SHW) - grp_c * AW'(DIGITS);
  end

  // recurrence
  logic [XLEN-1:0]   rem_nx;
  logic [DIGITS-1:0] qd;

  idiv_stage #(.W(XLEN), .DIGITS(DIGITS)) u_stage (
    .rem_i (rem_r),
    .den_i (mag_b),
    .bits_i(sh[SHW-1 -: DIGITS]),
    .rem_o (rem_nx),
    .q_o   (qd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      a_raw  <= '0;
      b_raw  <= '0;
      wide_r <= 1'b0;
      sgn_r  <= 1'b0;
      mag_a  <= '0;
      mag_b  <= '0;
      neg_q  <= 1'b0;
      neg_r  <= 1'b0;
      err_r  <= 1'b0;
      sh     <= '0;
      rem_r  <= '0;
      quo_r  <= '0;
      q_fix  <= '0;
      r_fix  <= '0;
      left   <= '0;
      done_o <= 1'b0;
      quot_o <= '0;
      rem_o  <= '0;
      err_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start_i) begin
            a_raw  <= dividend_i;
            b_raw  <= divisor_i;
            wide_r <= wide_i;
            sgn_r  <= signed_i;
            st     <= ST_ABS;
          end
        end
        ST_ABS: begin
          mag_a <= pa;
          mag_b <= pb;
          neg_q <= pnq;
          neg_r <= pnr;
          err_r <= perr;
          st    <= ST_NORM;
        end
        ST_NORM: begin
          rem_r <= '0;
          quo_r <= '0;
          sh    <= {{(SHW-XLEN){1'b0}}, mag_a} << shamt_c;
          left  <= n_c;
          if (err_r || n_c == '0) st <= ST_SIGN;
          else                    st <= ST_ITER;
        end
        ST_ITER: begin
          rem_r <= rem_nx;
          quo_r <= {quo_r[XLEN-DIGITS-1:0], qd};
          sh    <= sh << DIGITS;
          left  <= left - NW'(1);
          if (left == NW'(1)) st <= ST_SIGN;
        end
        ST_SIGN: begin
          q_fix <= neg_q ? -quo_r : quo_r;
          r_fix <= neg_r ? -rem_r : rem_r;
          st    <= ST_OUT;
        end
        ST_OUT: begin
          if (err_r) begin
            quot_o <= '0;
            rem_o  <= '0;
          end else if (wide_r) begin
            quot_o <= q_fix;
            rem_o  <= r_fix;
          end else begin
            quot_o <= {{HALF{1'b0}}, q_fix[HALF-1:0]};
            rem_o  <= {{HALF{1'b0}}, r_fix[HALF-1:0]};
          end
          err_o  <= err_r;
          done_o <= 1'b1;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st != ST_IDLE);
endmodule

// File: rtl/iter_div_chk.sv
`timescale 1ns/1ps
module iter_div_chk #(
  parameter int XLEN   = 64,
  parameter int DIGITS = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            start_i,
  input logic            wide_i,
  input logic            busy_o,
  input logic            done_o,
  input logic [XLEN-1:0] quot_o,
  input logic [XLEN-1:0] rem_o,
  input logic            err_o
);
  localparam int HALF  = XLEN / 2;
  localparam int MAXW  = 4 + (XLEN + DIGITS - 1) / DIGITS;
  localparam int MAXH  = 4 + (HALF + DIGITS - 1) / DIGITS;
  localparam int LW    = $clog2(MAXW + 2) + 1;

  logic [LW-1:0] lat;
  logic          wide_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat    <= '0;
      wide_q <= 1'b0;
    end else if (start_i && !busy_o) begin
      lat    <= '0;
      wide_q <= wide_i;
    end else if (busy_o && lat != '1) begin
      lat <= lat + LW'(1);
    end
  end

  // R7
  done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R7
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(quot_o) && $stable(rem_o) && $stable(err_o)));

  // R3
  narrow_zext_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !wide_q) |-> (quot_o[XLEN-1:HALF] == '0 && rem_o[XLEN-1:HALF] == '0));

  // R4
  fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && err_o) |-> (quot_o == '0 && rem_o == '0));

  // R5
  fault_fast_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && err_o) |-> (lat == LW'(4)));

  // R6
  latency_bound_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (lat >= LW'(4) && lat <= (wide_q ? LW'(MAXW) : LW'(MAXH))));
endmodule

bind iter_div iter_div_chk #(.XLEN(XLEN), .DIGITS(DIGITS)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start_i(start_i),
  .wide_i (wide_i),
  .busy_o (busy_o),
  .done_o (done_o),
  .quot_o (quot_o),
  .rem_o  (rem_o),
  .err_o  (err_o)
);

// File: tb/iter_div_bench.sv
`timescale 1ns/1ps
module iter_div_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [63:0] dividend_i = '0;
  logic [63:0] divisor_i = '0;
  logic        wide_i = 1'b0;
  logic        signed_i = 1'b0;
  logic        busy_o, done_o, err_o;
  logic [63:0] quot_o, rem_o;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  iter_div u_iter_div (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .dividend_i(dividend_i),
    .divisor_i (divisor_i),
    .wide_i    (wide_i),
    .signed_i  (signed_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .quot_o    (quot_o),
    .rem_o     (rem_o),
    .err_o     (err_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Expected results from the requirements
  function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                input bit wide, input bit sgn,
                                output logic [63:0] q, output logic [63:0] r,
                                output bit err, output int lat);
    logic [63:0] aw, bw, ma, mb, uq, ur;
    bit sa, sb;
    int s;
    aw = wide ? a : {32'h0, a[31:0]};
    bw = wide ? b : {32'h0, b[31:0]};
    sa = sgn && (wide ? a[63] : a[31]);
    sb = sgn && (wide ? b[63] : b[31]);
    ma = sa ? (wide ? -aw : {32'h0, 32'(-aw[31:0])}) : aw;
    mb = sb ? (wide ? -bw : {32'h0, 32'(-bw[31:0])}) : bw;
    err = (bw == 0) ||
          (sgn && (wide ? (aw == 64'h8000_0000_0000_0000 && bw == '1)
                        : (aw == 64'h8000_0000 && bw == 64'hFFFF_FFFF)));
    if (err) begin
      q = '0; r = '0; lat = 4;
    end else begin
      uq = ma / mb;
      ur = ma % mb;
      q = (sa ^ sb) ? -uq : uq;
      r = sa ? -ur : ur;
      if (!wide) begin
        q = {32'h0, q[31:0]};
        r = {32'h0, r[31:0]};
      end
      s = 0;
      for (int i = 0; i < 64; i++) if (ma[i]) s = i + 1;
      lat = 4 + (s + 2) / 3;
    end
  endfunction

  task automatic run_op(input logic [63:0] a, input logic [63:0] b,
                        input bit wide, input bit sgn, input string req,
                        input bit poke);
    logic [63:0] eq, er;
    bit ee, seen;
    int el, cnt;
    model(a, b, wide, sgn, eq, er, ee, el);
    @(negedge clk);
    dividend_i = a; divisor_i = b; wide_i = wide; signed_i = sgn; start_i = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b1, "R7", "busy after accept", 64'(busy_o), 64'd1);
    if (poke) begin
      // R8: a second start while busy must be ignored
      dividend_i = ~a; divisor_i = b ^ 64'h5; wide_i = ~wide; signed_i = ~sgn;
    end else begin
      start_i = 1'b0;
    end
    cnt = 0; seen = 1'b0;
    while (!seen && cnt < 40) begin
      @(negedge clk);
      start_i = 1'b0;
      cnt++;
      if (done_o) seen = 1'b1;
    end
    if (!seen) begin
      chk(1'b0, "R7", "no done pulse", 64'(cnt), 64'(el));
    end else begin
      chk(cnt == el, "R6", "latency", 64'(cnt), 64'(el));
      chk(quot_o == eq, req, "quotient", quot_o, eq);
      chk(rem_o == er, req, "remainder", rem_o, er);
      chk(err_o == ee, req, "error flag", 64'(err_o), 64'(ee));
      chk(busy_o == 1'b0, "R7", "busy during done", 64'(busy_o), 64'd0);
      @(negedge clk);
      chk(!done_o && quot_o == eq && rem_o == er, "R9", "result hold", quot_o, eq);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] a, b;
    int m;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    chk(!busy_o && !done_o && !err_o && quot_o == 0 && rem_o == 0, "R9",
        "reset outputs", quot_o | rem_o, 64'd0);

    // R1: unsigned 64-bit
    run_op(64'hdeadbeef_00112233, 64'h10, 1, 0, "R1", 0);
    run_op(64'hFFFFFFFF_FFFFFFFF, 64'h3, 1, 0, "R1", 0);
    run_op(64'h12345678_9ABCDEF0, 64'hFFFFFFFF_FFFFFFFF, 1, 0, "R1", 0);
    // R6: group boundaries
    run_op(64'd0, 64'd5, 1, 0, "R6", 0);
    run_op(64'd1, 64'd1, 1, 0, "R6", 0);
    run_op(64'd7, 64'd2, 1, 0, "R6", 0);
    run_op(64'd8, 64'd2, 1, 0, "R6", 0);
    run_op(64'hFFFFFFFF_FFFFFFFF, 64'h1, 0, 0, "R6", 0);
    // R2: signed sign combinations
    run_op(-64'sd7, 64'd2, 1, 1, "R2", 0);
    run_op(64'd7, -64'sd2, 1, 1, "R2", 0);
    run_op(-64'sd7, -64'sd2, 1, 1, "R2", 0);
    run_op(64'h0000_0000_FFFF_FFF9, 64'h2, 0, 1, "R2", 0);
    // R3: upper halves ignored in 32-bit mode
    run_op(64'hFFFF_FFFF_0000_0064, 64'h1234_5678_0000_0007, 0, 0, "R3", 0);
    run_op(64'hAAAA_5555_8000_0001, 64'h0F0F_0F0F_FFFF_FFFE, 0, 1, "R3", 0);
    // R4: zero divisor
    run_op(64'd1000, 64'd0, 1, 0, "R4", 0);
    run_op(64'd1000, 64'hABCD_0000_0000_0000, 0, 1, "R4", 0);
    // R5: signed overflow and its unsigned twin
    run_op(64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, "R5", 0);
    run_op(64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 0, 1, "R5", 0);
    run_op(64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, "R5", 0);
    // R8: start while busy
    run_op(64'h0123_4567_89AB_CDEF, 64'd1000, 1, 0, "R8", 1);
    run_op(64'h0000_0000_0765_4321, 64'd3, 0, 1, "R8", 1);

    for (int n = 0; n < 400; n++) begin
      a = {$urandom, $urandom} >> ($urandom % 64);
      m = $urandom % 16;
      if (m == 0)      b = 64'd0;
      else if (m == 1) b = '1;
      else             b = {$urandom, $urandom} >> ($urandom % 64);
      if (m == 2) a = 64'h8000_0000_8000_0000;
      if ($urandom % 2) run_op(a, b, 1'($urandom % 2), 1, "R2", 0);
      else if ($urandom % 2) run_op(a, b, 1, 0, "R1", 0);
      else run_op(a, b, 0, 0, "R3", 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule